// File: doc/BRIEF.md
# Micro-Op Slot Queue

This block buffers decoded instructions between an in-order front end and an out-of-order back end. Each instruction arrives with a micro-op count and a tag. It occupies that many consecutive entries of a circular slot store, with the count clamped to the queue size. A count of zero still takes one entry. Several instructions can be offered at once on parallel write lanes. The queue answers each lane in the same cycle, based on the free slots counted at the start of the cycle and on an optional cap on intake per cycle. A lane that is refused must hold its instruction and offer it again.

Instructions leave in arrival order, one whole instruction per cycle, through a valid/ready handshake that presents the tag and the slot count of the oldest instruction. A mode parameter picks one of two latencies. In the zero-latency mode an instruction accepted into an empty queue is shown downstream in the same cycle and can leave at once. In the one-cycle mode every instruction stays in the queue for at least one clock edge.

Top module: `uopq_slot_queue`

## Requirements
- R1: After reset the queue is empty: `busy` and `out_valid` are low, and the full capacity `NUM_SLOTS` is free for the first writes.
- R2: An instruction occupies max(1, min(count, `NUM_SLOTS`)) slots. `out_slots` reports this value for the instruction at the head.
- R3: Lanes are judged in order from lane 0 upward. A valid lane is accepted only if its slot need is no larger than the slots that were free at the start of the cycle, minus the needs of lower lanes accepted in the same cycle. A departure in the same cycle does not add to that cycle's free slots.
- R4: With `MAX_IPC` nonzero, at most `MAX_IPC` lanes are accepted per cycle. With `MAX_IPC` equal to 0 there is no such cap.
- R5: Once a valid lane is refused, every higher lane is refused in that cycle. Lanes with `in_valid` low are skipped, and an accept is never given without `in_valid`.
- R6: A refused lane changes no queue state. In a cycle with no accept and no departure, the free count stays the same.
- R7: Instructions depart whole and in acceptance order. A departure returns all of its slots to the free count for the next cycle.
- R8: An instruction departs only when `out_valid` and `out_ready` are both high, and at most one departs per cycle. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_tag` and `out_slots` hold.
- R9: In zero-latency mode with an empty queue, the lowest accepted lane of the cycle is presented on `out_valid`/`out_tag` in that cycle and may depart in that cycle.
- R10: In one-cycle mode, `out_valid` is low whenever the queue held nothing at the start of the cycle.
- R11: `busy` is high exactly when at least one slot is occupied.
- R12: Slot indices wrap modulo `NUM_SLOTS`, including for sizes that are not powers of two and for instructions that straddle the end of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | LANES | Per-lane write request |
| in_uops | input | LANES*UOP_W | Per-lane micro-op count, lane i at bits [i*UOP_W +: UOP_W] |
| in_tag | input | LANES*TAG_W | Per-lane instruction tag, lane i at bits [i*TAG_W +: TAG_W] |
| in_accept | output | LANES | Per-lane acceptance in the current cycle |
| out_valid | output | 1 | Head instruction available downstream |
| out_ready | input | 1 | Downstream takes the head instruction |
| out_tag | output | TAG_W | Tag of the head instruction |
| out_slots | output | $clog2(NUM_SLOTS+1) | Slots held by the head instruction |
| busy | output | 1 | At least one slot occupied |

## Verification
The bench builds two copies, each with three lanes and six slots. The size of six is not a power of two, so both index wraps and instructions that straddle the end of the store appear often. Four-bit counts go up to 15, which is far above six, so clamping and the oversized-into-empty case come up. The zero-latency copy has an intake cap of 2 with three lanes, so the cap refuses a third lane that would otherwise fit. The one-cycle copy has no cap, so all three lanes can enter in one cycle and fill the queue exactly.

// File: rtl/uopq_pkg.sv
package uopq_pkg;

    typedef enum logic {
        LAT_ZERO = 1'b0,
        LAT_ONE  = 1'b1
    } lat_mode_e;

    // base < size and off <= size, so a single subtraction wraps it
    function automatic int ring_add(int base, int off, int size);
        int s;
        s = base + off;
        if (s >= size) s = s - size;
        return s;
    endfunction

endpackage

// File: rtl/uopq_need_norm.sv
module uopq_need_norm #(
    parameter int UOP_W     = 4,
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 4
) (
    input  logic [UOP_W-1:0]  uops,
    output logic [SLOT_W-1:0] need
);

    always_comb begin
        if (uops == '0) begin
            need = SLOT_W'(1);
        end else if (int'(uops) > NUM_SLOTS) begin
            need = SLOT_W'(NUM_SLOTS);
        end else begin
            need = SLOT_W'(int'(uops));
        end
    end

endmodule

// File: rtl/uopq_admit.sv
module uopq_admit #(
    parameter int LANES   = 4,
    parameter int SLOT_W  = 4,
    parameter int MAX_IPC = 2
) (
    input  logic [LANES-1:0]             valid,
    input  logic [LANES-1:0][SLOT_W-1:0] need,
    input  logic [SLOT_W-1:0]            free_slots,
    output logic [LANES-1:0]             accept,
    output logic [LANES-1:0][SLOT_W-1:0] offset,
    output logic [SLOT_W-1:0]            total
);

    always_comb begin
        int   rem;
        int   used;
        int   taken;
        logic blocked;
        rem     = int'(free_slots);
        used    = 0;
        taken   = 0;
        blocked = 1'b0;
        accept  = '0;
        offset  = '0;
        for (int i = 0; i < LANES; i++) begin
            offset[i] = SLOT_W'(used);
            if (valid[i] && !blocked) begin
                if ((MAX_IPC == 0 || taken < MAX_IPC) && int'(need[i]) <= rem) begin
                    accept[i] = 1'b1;
                    rem   = rem - int'(need[i]);
                    used  = used + int'(need[i]);
                    taken = taken + 1;
                end else begin
                    blocked = 1'b1;
                end
            end
        end
        total = SLOT_W'(used);
    end

endmodule

// File: rtl/uopq_out_sel.sv
module uopq_out_sel
    import uopq_pkg::*;
#(
    parameter int        LANES    = 4,
    parameter int        TAG_W    = 8,
    parameter int        SLOT_W   = 4,
    parameter lat_mode_e LAT_MODE = LAT_ZERO
) (
    input  logic                         queue_empty,
    input  logic [TAG_W-1:0]             head_tag,
    input  logic [SLOT_W-1:0]            head_need,
    input  logic [LANES-1:0]             accept,
    input  logic [LANES-1:0][TAG_W-1:0]  lane_tag,
    input  logic [LANES-1:0][SLOT_W-1:0] lane_need,
    output logic                         out_valid,
    output logic [TAG_W-1:0]             out_tag,
    output logic [SLOT_W-1:0]            out_slots
);

    logic              allow_bypass;
    logic              bp_valid;
    logic [TAG_W-1:0]  bp_tag;
    logic [SLOT_W-1:0] bp_need;

    generate
        if (LAT_MODE == LAT_ZERO) begin : g_zero_lat
            assign allow_bypass = 1'b1;
        end else begin : g_one_lat
            assign allow_bypass = 1'b0;
        end
    endgenerate

    // lowest accepted lane is the oldest of this cycle's writes
    always_comb begin
        bp_valid = 1'b0;
        bp_tag   = '0;
        bp_need  = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (accept[i]) begin
                bp_valid = 1'b1;
                bp_tag   = lane_tag[i];
                bp_need  = lane_need[i];
            end
        end
    end

    always_comb begin
        if (!queue_empty) begin
            out_valid = 1'b1;
            out_tag   = head_tag;
            out_slots = head_need;
        end else begin
            out_valid = allow_bypass & bp_valid;
            out_tag   = bp_tag;
            out_slots = bp_need;
        end
    end

endmodule

// File: rtl/uopq_slot_queue.sv
module uopq_slot_queue
    import uopq_pkg::*;
#(
    parameter int        LANES     = 4,
    parameter int        NUM_SLOTS = 8,
    parameter int        UOP_W     = 4,
    parameter int        TAG_W     = 8,
    parameter int        MAX_IPC   = 2,
    parameter lat_mode_e LAT_MODE  = LAT_ZERO,
    localparam int       SLOT_W    = $clog2(NUM_SLOTS + 1),
    localparam int       IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         in_valid,
    input  logic [LANES*UOP_W-1:0]   in_uops,
    input  logic [LANES*TAG_W-1:0]   in_tag,
    output logic [LANES-1:0]         in_accept,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [TAG_W-1:0]         out_tag,
    output logic [SLOT_W-1:0]        out_slots,
    output logic                     busy
);

    typedef struct packed {
        logic [SLOT_W-1:0]                 free;
        logic [IDX_W-1:0]                  head;
        logic [IDX_W-1:0]                  tail;
        logic [NUM_SLOTS-1:0][TAG_W-1:0]   tags;
        logic [NUM_SLOTS-1:0][SLOT_W-1:0]  needs;
    } state_t;

    state_t st_q, st_d;

    logic [LANES-1:0][SLOT_W-1:0] lane_need;
    logic [LANES-1:0][SLOT_W-1:0] lane_off;
    logic [LANES-1:0][TAG_W-1:0]  lane_tag;
    logic [SLOT_W-1:0]            acc_total;
    logic                         queue_empty;
    logic                         depart;
    logic [SLOT_W-1:0]            free_q;

    assign lane_tag    = in_tag;
    assign queue_empty = (st_q.free == SLOT_W'(NUM_SLOTS));
    assign busy        = ~queue_empty;
    assign depart      = out_valid & out_ready;
    assign free_q      = st_q.free;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            uopq_need_norm #(
                .UOP_W    (UOP_W),
                .NUM_SLOTS(NUM_SLOTS),
                .SLOT_W   (SLOT_W)
            ) u_norm (
                .uops(in_uops[g*UOP_W +: UOP_W]),
                .need(lane_need[g])
            );
        end
    endgenerate

    uopq_admit #(
        .LANES  (LANES),
        .SLOT_W (SLOT_W),
        .MAX_IPC(MAX_IPC)
    ) u_admit (
        .valid     (in_valid),
        .need      (lane_need),
        .free_slots(st_q.free),
        .accept    (in_accept),
        .offset    (lane_off),
        .total     (acc_total)
    );

    uopq_out_sel #(
        .LANES   (LANES),
        .TAG_W   (TAG_W),
        .SLOT_W  (SLOT_W),
        .LAT_MODE(LAT_MODE)
    ) u_out (
        .queue_empty(queue_empty),
        .head_tag   (st_q.tags[st_q.head]),
        .head_need  (st_q.needs[st_q.head]),
        .accept     (in_accept),
        .lane_tag   (lane_tag),
        .lane_need  (lane_need),
        .out_valid  (out_valid),
        .out_tag    (out_tag),
        .out_slots  (out_slots)
    );

    // next state: write accepted lanes at their ring offsets, advance pointers
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LANES; i++) begin
            if (in_accept[i]) begin
                st_d.tags[ring_add(int'(st_q.tail), int'(lane_off[i]), NUM_SLOTS)]  = lane_tag[i];
                st_d.needs[ring_add(int'(st_q.tail), int'(lane_off[i]), NUM_SLOTS)] = lane_need[i];
            end
        end
        st_d.tail = IDX_W'(ring_add(int'(st_q.tail), int'(acc_total), NUM_SLOTS));
        if (depart) begin
            st_d.head = IDX_W'(ring_add(int'(st_q.head), int'(out_slots), NUM_SLOTS));
            st_d.free = st_q.free - acc_total + out_slots;
        end else begin
            st_d.free = st_q.free - acc_total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.free <= SLOT_W'(NUM_SLOTS);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/uopq_checker.sv
module uopq_checker
    import uopq_pkg::*;
#(
    parameter int        LANES     = 4,
    parameter int        NUM_SLOTS = 8,
    parameter int        TAG_W     = 8,
    parameter int        MAX_IPC   = 2,
    parameter lat_mode_e LAT_MODE  = LAT_ZERO,
    parameter int        SLOT_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LANES-1:0]  in_valid,
    input logic [LANES-1:0]  in_accept,
    input logic              out_valid,
    input logic              out_ready,
    input logic [TAG_W-1:0]  out_tag,
    input logic [SLOT_W-1:0] out_slots,
    input logic              busy,
    input logic [SLOT_W-1:0] free_cnt
);

    // R5: accept only on a requesting lane
    a_r5_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_accept & ~in_valid) == '0);

    // R3: free count never exceeds capacity
    a_r3_free_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_cnt) <= NUM_SLOTS);

    // R6: no accept and no departure leaves free count untouched
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (in_accept == '0 && !(out_valid && out_ready)) |=> $stable(free_cnt));

    // R8: a stalled head holds
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_slots)));

    generate
        if (MAX_IPC != 0) begin : g_cap
            // R4: intake cap
            a_r4_intake_cap: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(in_accept) <= MAX_IPC);
        end
        if (LAT_MODE == LAT_ONE) begin : g_one
            // R10: nothing leaves an empty queue in one-cycle mode
            a_r10_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
                !busy |-> !out_valid);
        end else begin : g_zero
            // R9: output only from stored content or a same-cycle accept
            a_r9_bypass_source: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (busy || in_accept != '0));
        end
    endgenerate

endmodule

bind uopq_slot_queue uopq_checker #(
    .LANES    (LANES),
    .NUM_SLOTS(NUM_SLOTS),
    .TAG_W    (TAG_W),
    .MAX_IPC  (MAX_IPC),
    .LAT_MODE (LAT_MODE),
    .SLOT_W   (SLOT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_accept(in_accept),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_tag  (out_tag),
    .out_slots(out_slots),
    .busy     (busy),
    .free_cnt (free_q)
);

// File: tb/tb_uopq_slot_queue.sv
module tb_uopq_slot_queue;
    import uopq_pkg::*;

    localparam int PERIOD = 10;
    localparam int L      = 3;
    localparam int N      = 6;
    localparam int UW     = 4;
    localparam int TW     = 8;
    localparam int SW     = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [L-1:0]    in_valid = '0;
    logic [L*UW-1:0] in_uops = '0;
    logic [L*TW-1:0] in_tag = '0;
    logic            out_ready = 1'b0;

    logic [L-1:0]  acc_z, acc_d;
    logic          ov_z, ov_d, busy_z, busy_d;
    logic [TW-1:0] tag_z, tag_d;
    logic [SW-1:0] sl_z, sl_d;

    int n_chk = 0;
    int n_fail = 0;
    int q_z[$];
    int q_d[$];
    int free_z = N;
    int free_d = N;

    always #(PERIOD / 2) clk = ~clk;

    uopq_slot_queue #(.LANES(L), .NUM_SLOTS(N), .UOP_W(UW), .TAG_W(TW),
                      .MAX_IPC(2), .LAT_MODE(LAT_ZERO)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
        .in_tag(in_tag), .in_accept(acc_z), .out_valid(ov_z), .out_ready(out_ready),
        .out_tag(tag_z), .out_slots(sl_z), .busy(busy_z));

    uopq_slot_queue #(.LANES(L), .NUM_SLOTS(N), .UOP_W(UW), .TAG_W(TW),
                      .MAX_IPC(0), .LAT_MODE(LAT_ONE)) dut_d1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
        .in_tag(in_tag), .in_accept(acc_d), .out_valid(ov_d), .out_ready(out_ready),
        .out_tag(tag_d), .out_slots(sl_d), .busy(busy_d));

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    function automatic int norm(int u);
        if (u == 0) return 1;
        if (u > N) return N;
        return u;
    endfunction

    // entry encoding in the model: tag*16 + slots
    task automatic model_step(ref int mq[$], ref int fr, input string id, input int cap,
                              input bit zl, input int a_acc, input int a_ov,
                              input int a_tag, input int a_sl, input int a_busy);
        int rem = fr;
        int taken = 0;
        bit blk = 0;
        int eacc = 0;
        int pushed[$];
        int eov;
        int e;
        for (int i = 0; i < L; i++) begin
            if (in_valid[i] && !blk) begin
                int n = norm(int'(in_uops[i*UW +: UW]));
                if ((cap == 0 || taken < cap) && n <= rem) begin
                    eacc |= (1 << i);
                    rem -= n;
                    taken++;
                    pushed.push_back(int'(in_tag[i*TW +: TW]) * 16 + n);
                end else begin
                    blk = 1;
                end
            end
        end
        chk({id, " R3,R4,R5 accept"}, a_acc, eacc);
        chk({id, " R6,R11 busy"}, a_busy, (fr != N) ? 1 : 0);
        eov = (mq.size() > 0 || (zl && pushed.size() > 0)) ? 1 : 0;
        chk({id, " R8,R9,R10 out_valid"}, a_ov, eov);
        if (eov != 0) begin
            e = (mq.size() > 0) ? mq[0] : pushed[0];
            chk({id, " R7,R12 out_tag order"}, a_tag, e / 16);
            chk({id, " R2 out_slots"}, a_sl, e % 16);
        end
        fr = rem;
        foreach (pushed[k]) mq.push_back(pushed[k]);
        if (eov != 0 && out_ready) begin
            e = mq.pop_front();
            fr += e % 16;
        end
    endtask

    task automatic step();
        #1;
        model_step(q_z, free_z, "zero", 2, 1'b1, int'(acc_z), int'(ov_z), int'(tag_z), int'(sl_z), int'(busy_z));
        model_step(q_d, free_d, "one", 0, 1'b0, int'(acc_d), int'(ov_d), int'(tag_d), int'(sl_d), int'(busy_d));
        @(negedge clk);
    endtask

    task automatic drive(int pv, int maxu, int pr);
        for (int i = 0; i < L; i++) begin
            in_valid[i]         = ($urandom_range(0, 99) < pv);
            in_uops[i*UW +: UW] = UW'($urandom_range(0, maxu));
            in_tag[i*TW +: TW]  = TW'($urandom_range(0, 255));
        end
        out_ready = ($urandom_range(0, 99) < pr);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(7));
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset out_valid zero", int'(ov_z), 0);
        chk("R1 reset busy zero", int'(busy_z), 0);
        chk("R1 reset out_valid one", int'(ov_d), 0);
        chk("R1 reset busy one", int'(busy_d), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // first write: three lanes of 2 slots, capacity 6
        in_valid = 3'b111;
        in_uops  = {4'd2, 4'd2, 4'd2};
        in_tag   = {8'd30, 8'd20, 8'd10};
        out_ready = 1'b0;
        #1;
        chk("R1 R4 capped first accept zero", int'(acc_z), 3);
        chk("R1 full capacity first accept one", int'(acc_d), 7);
        chk("R9 bypass tag", int'(tag_z), 10);
        step();
        for (int c = 0; c < 300; c++) begin drive(60, 8, 80); step(); end
        for (int c = 0; c < 200; c++) begin drive(80, 15, 20); step(); end
        for (int c = 0; c < 20; c++) begin in_valid = '0; out_ready = 1'b1; step(); end
        // oversized instruction into empty queue is clamped to full size
        in_valid = 3'b001;
        in_uops  = {4'd0, 4'd0, 4'd15};
        in_tag   = {8'd0, 8'd0, 8'd99};
        out_ready = 1'b0;
        #1;
        chk("R2 clamp accept", int'(acc_z), 1);
        chk("R2 clamp slots bypass", int'(sl_z), N);
        chk("R10 no same-cycle output", int'(ov_d), 0);
        step();
        for (int c = 0; c < 300; c++) begin drive(70, 3, 60); step(); end
        for (int c = 0; c < 300; c++) begin drive(50, 15, 50); step(); end
        summary();
        $finish;
    end

endmodule